// File: doc/BRIEF.md
# Reloading Two-Phase Pulse Generator

The block drives an endless train of pulses on one serial output. Every pulse begins with a high phase and ends with a low phase. Software sets each phase length as a count of clock ticks through a small write port, and the pulse period is the sum of the two lengths. The next pulse follows the last one without any software action.

When a pulse begins, the block copies both length registers into its own counters. Software may therefore rewrite the lengths at any point during a pulse with no race: the change governs the next pulse, not the one in flight. Nodes can keep the period fixed and move the boundary between high and low time to signal a small state code. One example is a one-tick-in-ten high time for a follower and two-in-ten for the leader.

An enable bit starts and stops the train. Clearing it forces the output low and drops the pulse in progress. Setting it again begins a fresh pulse with freshly latched lengths. A one-cycle strobe marks the first cycle of every pulse.

Top module: `phase_pulse_gen`

## Requirements
- R1: While reset is held and after reset releases, pulseOut and pulseStart are 0, the enable bit is 0, and both length registers hold 1.
- R2: A pulse drives pulseOut high for exactly H cycles and then low for exactly L cycles. H and L are the lengths latched at that pulse's start, so the period is H+L cycles.
- R3: While enabled, the cycle after a low phase's last cycle is the first high cycle of the next pulse. No write is needed for this.
- R4: A length write made during a pulse leaves that pulse's high and low durations unchanged and takes effect from the following pulse start.
- R5: A length write at the same clock edge that starts a pulse is not seen by that pulse. It applies from the next pulse.
- R6: A length value of 0 is treated as 1 tick.
- R7: In the cycle after an edge that writes the enable bit to 0, pulseOut and pulseStart are 0, and they stay 0 while the bit remains 0. Once the bit reads 1, the next edge starts a fresh pulse with the current register values.
- R8: pulseStart is high for exactly one cycle per pulse: the first cycle of the high phase, which is the only cycle in which pulseOut rises.
- R9: Write select codes: 0 writes the high length, 1 writes the low length, 2 writes the enable bit from wrData[0], and 3 is ignored and changes nothing.
- R10: With H+L held constant, changing the split between H and L keeps the period at H+L cycles while the high time follows H. This lets the split carry a state code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select (0 high, 1 low, 2 enable, 3 none) |
| wrData | input | 32 | Write data |
| pulseOut | output | 1 | Serial pulse output |
| pulseStart | output | 1 | One-cycle strobe in the first cycle of each pulse |

## Verification
The assertions assume that wrSel and wrData are stable and known at each edge where wrEn is high, and that reset is released only between edges. Under those conditions every rise of pulseOut must carry a start strobe, and a disable write must silence both outputs.

The stimulus drives all inputs on the falling edge, so no write overlaps a sampling edge. Random lengths are kept small so that many pulses, restarts and mid-pulse rewrites fit in the run. Directed cases place writes exactly on a pulse-start edge and test zero lengths.

// File: rtl/phase_pulse_pkg.sv
package phase_pulse_pkg;

  typedef enum logic [1:0] {
    SEL_HIGH = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } wrSel_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic startPulse; // latch both lengths, begin high phase
    logic enterLow;   // load latched low length
    logic countDown;  // decrement the phase counter
  } ctrlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic enabled;
    logic lastTick;
  } dpStatus_t;

endpackage

// File: rtl/phase_pulse_dp.sv
module phase_pulse_dp
  import phase_pulse_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int SEL_W = 2,
  parameter logic [LEN_W-1:0] RESET_HIGH = 1,
  parameter logic [LEN_W-1:0] RESET_LOW = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [LEN_W-1:0] wrData,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam int NREG = 2;

  logic [LEN_W-1:0] lenReg [NREG];
  logic [LEN_W-1:0] lenEff [NREG];
  logic             enReg;
  logic [LEN_W-1:0] phaseCnt;
  logic [LEN_W-1:0] lowHold;

  // Programmable length registers, one per phase
  for (genvar g = 0; g < NREG; g++) begin : gLenReg
    localparam logic [LEN_W-1:0] INIT = (g == 0) ? RESET_HIGH : RESET_LOW;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lenReg[g] <= INIT;
      end else if (wrEn && (wrSel == SEL_W'(g))) begin
        lenReg[g] <= wrData;
      end
    end
    // Zero length is stretched to a single tick
    always_comb begin
      lenEff[g] = (lenReg[g] == '0) ? ONE : lenReg[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= 1'b0;
    end else if (wrEn && (wrSel == SEL_W'(SEL_EN))) begin
      enReg <= wrData[0];
    end
  end

  // Working counters, loaded only at pulse boundaries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= ONE;
      lowHold  <= ONE;
    end else if (strobe.startPulse) begin
      phaseCnt <= lenEff[0];
      lowHold  <= lenEff[1];
    end else if (strobe.enterLow) begin
      phaseCnt <= lowHold;
    end else if (strobe.countDown && (phaseCnt != ONE)) begin
      phaseCnt <= phaseCnt - ONE;
    end
  end

  always_comb begin
    status.enabled  = enReg;
    status.lastTick = (phaseCnt == ONE);
  end

endmodule

// File: rtl/phase_pulse_ctrl.sv
module phase_pulse_ctrl
  import phase_pulse_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        pulseOut,
  output logic        pulseStart
);

  phase_e phase, phaseNext;
  logic   startQ;

  always_comb begin
    strobe    = '0;
    phaseNext = phase;
    if (!status.enabled) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          strobe.startPulse = 1'b1;
          phaseNext = PH_HIGH;
        end
        PH_HIGH: begin
          if (status.lastTick) begin
            strobe.enterLow = 1'b1;
            phaseNext = PH_LOW;
          end else begin
            strobe.countDown = 1'b1;
          end
        end
        PH_LOW: begin
          if (status.lastTick) begin
            strobe.startPulse = 1'b1;
            phaseNext = PH_HIGH;
          end else begin
            strobe.countDown = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      startQ <= 1'b0;
    end else begin
      phase  <= phaseNext;
      startQ <= strobe.startPulse;
    end
  end

  // Enable gates the outputs so a disable silences them at once
  always_comb begin
    pulseOut   = (phase == PH_HIGH) && status.enabled;
    pulseStart = startQ && status.enabled;
  end

endmodule

// File: rtl/phase_pulse_gen.sv
module phase_pulse_gen
  import phase_pulse_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [LEN_W-1:0] wrData,
  output logic             pulseOut,
  output logic             pulseStart
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  phase_pulse_dp #(
    .LEN_W(LEN_W),
    .SEL_W(SEL_W)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .strobe (strobe),
    .status (status)
  );

  phase_pulse_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .status     (status),
    .strobe     (strobe),
    .pulseOut   (pulseOut),
    .pulseStart (pulseStart)
  );

endmodule

// File: rtl/phase_pulse_chk.sv
module phase_pulse_chk #(
  parameter int LEN_W = 32,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [SEL_W-1:0] wrSel,
  input logic [LEN_W-1:0] wrData,
  input logic             pulseOut,
  input logic             pulseStart
);

  assert_rise_strobed_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOut) |-> pulseStart);

  assert_strobe_on_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    pulseStart |-> pulseOut);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    pulseStart |=> !pulseStart);

  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_W'(2) && !wrData[0]) |=> (!pulseOut && !pulseStart));

  assert_fall_no_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseOut) |-> !pulseStart);

endmodule

bind phase_pulse_gen phase_pulse_chk #(.LEN_W(LEN_W), .SEL_W(SEL_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .pulseOut   (pulseOut),
  .pulseStart (pulseStart)
);

// File: tb/test_phase_pulse_gen.sv
module test_phase_pulse_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic        pulseOut;
  logic        pulseStart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  bit          mEn = 1'b0;
  logic [31:0] mHigh = 32'd1;
  logic [31:0] mLow = 32'd1;
  int          mPhase = 0;      // 0 idle, 1 high, 2 low
  logic [31:0] mLeft = 32'd1;
  logic [31:0] mLowLatch = 32'd1;
  bit          mStart = 1'b0;

  always #5 clk = ~clk;

  phase_pulse_gen i_phase_pulse_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .pulseOut(pulseOut), .pulseStart(pulseStart)
  );

  function automatic logic [31:0] eff(input logic [31:0] v);
    return (v == 0) ? 32'd1 : v; // R6
  endfunction

  function automatic bit startsNext();
    return mEn && (mPhase == 0 || (mPhase == 2 && mLeft == 1));
  endfunction

  function automatic bit expOut();
    return (mPhase == 1) && mEn;
  endfunction

  function automatic bit expStart();
    return mStart && mEn;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelEdge(input bit we, input logic [1:0] sel, input logic [31:0] d);
    if (!mEn) begin
      mPhase = 0; mStart = 0;
    end else if (startsNext()) begin
      mPhase = 1; mLeft = eff(mHigh); mLowLatch = eff(mLow); mStart = 1;
    end else begin
      mStart = 0;
      if (mPhase == 1) begin
        if (mLeft == 1) begin mPhase = 2; mLeft = mLowLatch; end
        else mLeft = mLeft - 1;
      end else if (mPhase == 2) begin
        mLeft = mLeft - 1;
      end
    end
    if (we) begin
      case (sel)
        2'd0: mHigh = d;
        2'd1: mLow = d;
        2'd2: mEn = d[0];
        default: ;
      endcase
    end
  endtask

  // One cycle: drive at negedge, edge, compare at following negedge
  task automatic step(input string req, input bit we = 0,
                      input logic [1:0] sel = 0, input logic [31:0] d = 0);
    wrEn = we; wrSel = sel; wrData = d;
    @(posedge clk);
    modelEdge(we, sel, d);
    @(negedge clk);
    wrEn = 1'b0;
    check(req, pulseOut, expOut(), "pulseOut");
    check(req, pulseStart, expStart(), "pulseStart");
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic waitStartEdge(input string req);
    int guard = 0;
    while (!startsNext() && guard < 100) begin step(req); guard++; end
  endtask

  // Count cycles between two successive strobes and the high cycles in that span
  task automatic measure(input string req, input int expPeriod, input int expHigh);
    int per = 0, hi = 0, guard = 0;
    while (!pulseStart && guard < 200) begin step(req); guard++; end
    do begin
      if (pulseOut) hi++;
      per++;
      step(req);
    end while (!pulseStart && per < 200);
    checks++;
    if (per != expPeriod || hi != expHigh) begin
      errors++;
      $display("FAIL %s period/high actual=%0d/%0d expected=%0d/%0d", req, per, hi, expPeriod, expHigh);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1", pulseOut, 1'b0, "pulseOut in reset");
    check("R1", pulseStart, 1'b0, "pulseStart in reset");
    rstN = 1'b1;
    idle("R1", 4); // enable 0: outputs stay low

    // R1: reset lengths are 1, so enabling alone gives period 2
    step("R1", 1, 2'd2, 32'd1);
    measure("R1", 2, 1);

    // R2 R3 R8: H=3 L=2, back-to-back pulses
    step("R2", 1, 2'd0, 32'd3);
    step("R2", 1, 2'd1, 32'd2);
    idle("R3", 12);
    measure("R2", 5, 3);
    measure("R3", 5, 3);

    // R6: zero lengths act as one tick
    step("R6", 1, 2'd0, 32'd0);
    step("R6", 1, 2'd1, 32'd0);
    measure("R6", 2, 1);
    idle("R6", 5);

    // R4: mid-pulse rewrite affects the next pulse only
    step("R4", 1, 2'd0, 32'd4);
    step("R4", 1, 2'd1, 32'd4);
    idle("R4", 10);
    while (!pulseStart) step("R4");
    step("R4", 1, 2'd0, 32'd1);
    step("R4", 1, 2'd1, 32'd2);
    idle("R4", 14);

    // R5: write landing on the pulse-start edge
    waitStartEdge("R5");
    step("R5", 1, 2'd0, 32'd6);
    idle("R5", 16);
    waitStartEdge("R5");
    step("R5", 1, 2'd1, 32'd5);
    idle("R5", 16);

    // R7: disable mid-pulse, then re-enable
    step("R7", 1, 2'd0, 32'd5);
    step("R7", 1, 2'd1, 32'd3);
    while (!pulseStart) step("R7");
    step("R7");
    step("R7", 1, 2'd2, 32'd0);
    idle("R7", 6);
    step("R7", 1, 2'd2, 32'd1);
    idle("R7", 12);

    // R9: select 3 changes nothing
    step("R9", 1, 2'd3, 32'd0);
    step("R9", 1, 2'd3, 32'd9);
    measure("R9", 8, 5);

    // R10: fixed period of 10, state code in the split
    step("R10", 1, 2'd0, 32'd1);
    step("R10", 1, 2'd1, 32'd9);
    idle("R10", 12);
    measure("R10", 10, 1);
    step("R10", 1, 2'd0, 32'd2);
    step("R10", 1, 2'd1, 32'd8);
    idle("R10", 12);
    measure("R10", 10, 2);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 8)       step("R4", 1, 2'd0, $urandom_range(0, 6));
      else if (r < 16) step("R4", 1, 2'd1, $urandom_range(0, 6));
      else if (r < 18) step("R7", 1, 2'd2, {31'd0, ($urandom_range(0, 3) != 0)});
      else if (r < 20) step("R9", 1, 2'd3, $urandom);
      else             step("R2");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule